// File: doc/BRIEF.md
# Serial Port FIFO Status Block

This block holds the receive and transmit data queues of a synchronous serial port and produces the status that software and the DMA engine see. The serial shifter pushes received words into the receive queue and pops outgoing words from the transmit queue. The CPU or DMA engine does the opposite on each queue. Each queue is sixteen words deep by default.

Each queue reports its fill level in a 4-bit field that wraps around, so an empty queue and a full queue show the same code. A separate flag tells the two apart. A receive word that arrives while the receive queue is full is thrown away and sets a sticky overrun flag. The overrun flag always raises the interrupt and is cleared by writing a one to it.

A programmable receive trigger level drives a service flag. The service flag is routed to the interrupt line or to the DMA request according to two enable inputs. Turning the port off empties both queues.

Top module: `serial_fifo_status`

## Requirements
- R1: After reset both queues are empty: `rx_level` is 0xF, `rx_not_empty` is 0, `tx_level` is 0x0, `tx_not_full` is 1, and `rx_overrun`, `irq` and `dma_req` are 0.
- R2: `rx_level` equals (receive entry count − 1) mod 16, so both empty and full read 0xF. `rx_not_empty` is 1 exactly when the count is nonzero.
- R3: `tx_level` equals the transmit entry count mod 16, so both empty and full read 0x0. `tx_not_full` is 1 exactly when the count is below 16.
- R4: Each queue returns words in the order they were pushed. The `*_pop_data` port always shows the oldest stored word. A pop on an empty queue is ignored.
- R5: A receive push on a full queue without a pop in the same cycle drops the word and sets `rx_overrun` at the next edge. The count stays at 16, and further pushes are dropped as well.
- R6: A receive push and a pop in the same cycle on a full queue are both accepted. The count stays at 16 and no overrun is raised.
- R7: `ovr_wr` with `ovr_wdata`=1 clears `rx_overrun` at the next edge, and with `ovr_wdata`=0 it has no effect. A new overrun in the same cycle as a clear leaves the flag set.
- R8: `rx_service` is 1 exactly when `port_en` is 1 and the receive count is at least `rx_thresh`+1 (field values 0..15 select levels 1..16). It follows the count without extra delay and is 0 while the port is off.
- R9: `irq` = `rx_overrun` OR (`rx_service` AND `rx_irq_en`). The overrun part cannot be masked.
- R10: `dma_req` = `rx_service` AND `rx_dma_en` AND NOT `rx_irq_en`. The overrun flag never drives it, and the interrupt wins if both enables are set.
- R11: While `port_en` is 0, both queues are emptied at each edge and pushes and pops are ignored. A pending `rx_overrun` is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low flushes both queues |
| rx_push | input | 1 | Receive word from the shifter |
| rx_push_data | input | DATA_W | Received word |
| rx_pop | input | 1 | CPU/DMA read of the receive queue |
| rx_pop_data | output | DATA_W | Oldest receive word |
| tx_push | input | 1 | CPU/DMA write into the transmit queue |
| tx_push_data | input | DATA_W | Word to transmit |
| tx_pop | input | 1 | Shifter takes a transmit word |
| tx_pop_data | output | DATA_W | Oldest transmit word |
| rx_thresh | input | log2(DEPTH) | Receive trigger level minus one |
| rx_irq_en | input | 1 | Route service flag to interrupt |
| rx_dma_en | input | 1 | Route service flag to DMA request |
| ovr_wr | input | 1 | Status write strobe |
| ovr_wdata | input | 1 | Write data for the overrun bit (1 clears) |
| rx_level | output | log2(DEPTH) | Receive count minus one, wrapped |
| tx_level | output | log2(DEPTH) | Transmit count, wrapped |
| rx_not_empty | output | 1 | Receive queue holds data |
| tx_not_full | output | 1 | Transmit queue has room |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_service | output | 1 | Receive level at or above trigger |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 1 | Receive DMA request |

## Verification
Two pairs of events can land on the same edge: a push onto the full receive queue together with a pop, and a fresh overrun together with a write-one clear. The bench fills the receive queue to exactly sixteen words and then drives each pair in one cycle. For the first pair it checks that the count stays full, that the overrun flag stays low, and that the new word comes out last. For the second pair it checks that the flag stays set, which shows that setting wins over clearing.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  // Next-state action for the sticky overrun flag.
  typedef enum logic [1:0] {
    OVR_KEEP  = 2'd0,
    OVR_SET   = 2'd1,
    OVR_CLEAR = 2'd2
  } ovr_act_e;
endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       pop,
  output logic [DATA_W-1:0]          rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [AW-1:0]     wr_inc, rd_inc;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop & ~empty & ~flush;
  assign do_push = push & ~flush & (~full | do_pop);
  assign drop    = push & ~flush & full & ~pop;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_inc = wr_ptr_q + AW'(1);
      assign rd_inc = rd_ptr_q + AW'(1);
    end else begin : g_wrap
      assign wr_inc = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
      assign rd_inc = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
    end
  endgenerate

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = wr_inc;
      if (do_pop)  rd_ptr_d = rd_inc;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage carries no reset; only written entries are ever read.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  assign rdata = mem[rd_ptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/sfs_rx_status.sv
module sfs_rx_status
  import sfs_pkg::*;
#(
  parameter int LW = 4,
  parameter int CW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic [CW-1:0] rx_cnt,
  input  logic [LW-1:0] thresh,
  input  logic          drop,
  input  logic          clr_wr,
  input  logic          clr_bit,
  input  logic          irq_en,
  input  logic          dma_en,
  output logic          ovr,
  output logic          svc,
  output logic          irq,
  output logic          dma
);
  ovr_act_e act;
  logic     ovr_q, ovr_d;

  // Level >= thresh+1 is the same as level > thresh.
  assign svc = port_en & (rx_cnt > CW'(thresh));

  always_comb begin
    if (drop)                 act = OVR_SET;
    else if (clr_wr & clr_bit) act = OVR_CLEAR;
    else                      act = OVR_KEEP;
    case (act)
      OVR_SET:   ovr_d = 1'b1;
      OVR_CLEAR: ovr_d = 1'b0;
      default:   ovr_d = ovr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign ovr = ovr_q;
  assign irq = ovr_q | (svc & irq_en);
  assign dma = svc & dma_en & ~irq_en;
endmodule

// File: rtl/serial_fifo_status.sv
module serial_fifo_status #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int LW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_pop_data,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_push_data,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_pop_data,
  input  logic [LW-1:0]     rx_thresh,
  input  logic              rx_irq_en,
  input  logic              rx_dma_en,
  input  logic              ovr_wr,
  input  logic              ovr_wdata,
  output logic [LW-1:0]     rx_level,
  output logic [LW-1:0]     tx_level,
  output logic              rx_not_empty,
  output logic              tx_not_full,
  output logic              rx_overrun,
  output logic              rx_service,
  output logic              irq,
  output logic              dma_req
);
  localparam int CW = LW + 1;

  logic [CW-1:0] rx_cnt, tx_cnt, rx_cnt_m1;
  logic          rx_drop, tx_drop_unused;

  sfs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .flush(~port_en),
    .push(rx_push), .wdata(rx_push_data),
    .pop(rx_pop), .rdata(rx_pop_data),
    .count(rx_cnt), .drop(rx_drop)
  );

  sfs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .flush(~port_en),
    .push(tx_push), .wdata(tx_push_data),
    .pop(tx_pop), .rdata(tx_pop_data),
    .count(tx_cnt), .drop(tx_drop_unused)
  );

  sfs_rx_status #(.LW(LW), .CW(CW)) u_stat (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .rx_cnt(rx_cnt), .thresh(rx_thresh), .drop(rx_drop),
    .clr_wr(ovr_wr), .clr_bit(ovr_wdata),
    .irq_en(rx_irq_en), .dma_en(rx_dma_en),
    .ovr(rx_overrun), .svc(rx_service), .irq(irq), .dma(dma_req)
  );

  assign rx_cnt_m1    = rx_cnt - CW'(1);
  assign rx_level     = rx_cnt_m1[LW-1:0];
  assign tx_level     = tx_cnt[LW-1:0];
  assign rx_not_empty = (rx_cnt != '0);
  assign tx_not_full  = (tx_cnt < CW'(DEPTH));
endmodule

// File: rtl/serial_fifo_status_chk.sv
module serial_fifo_status_chk #(
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_en,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_irq_en,
  input logic          rx_dma_en,
  input logic          ovr_wr,
  input logic          ovr_wdata,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level,
  input logic          rx_not_empty,
  input logic          tx_not_full,
  input logic          rx_overrun,
  input logic          rx_service,
  input logic          irq,
  input logic          dma_req
);
  logic rx_full, push_on_full;
  assign rx_full      = rx_not_empty && (rx_level == '1);
  assign push_on_full = port_en && rx_push && !rx_pop && rx_full;

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_on_full |=> (rx_overrun && rx_full));

  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !(ovr_wr && ovr_wdata)) |=> rx_overrun);

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_wr && ovr_wdata && !push_on_full) |=> !rx_overrun);

  // R9
  ovr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> irq);

  // R10
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (rx_service && rx_dma_en && !rx_irq_en));

  // R8
  svc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !rx_service);

  // R3
  tx_full_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_not_full |-> (tx_level == '0));

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!rx_not_empty && tx_not_full && tx_level == '0));
endmodule

bind serial_fifo_status serial_fifo_status_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en),
  .rx_push(rx_push), .rx_pop(rx_pop),
  .rx_irq_en(rx_irq_en), .rx_dma_en(rx_dma_en),
  .ovr_wr(ovr_wr), .ovr_wdata(ovr_wdata),
  .rx_level(rx_level), .tx_level(tx_level),
  .rx_not_empty(rx_not_empty), .tx_not_full(tx_not_full),
  .rx_overrun(rx_overrun), .rx_service(rx_service),
  .irq(irq), .dma_req(dma_req)
);

// File: tb/test_serial_fifo_status.sv
`timescale 1ns/1ps
module test_serial_fifo_status;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n, port_en;
  logic rx_push, rx_pop, tx_push, tx_pop;
  logic [DW-1:0] rx_push_data, tx_push_data, rx_pop_data, tx_pop_data;
  logic [3:0] rx_thresh, rx_level, tx_level;
  logic rx_irq_en, rx_dma_en, ovr_wr, ovr_wdata;
  logic rx_not_empty, tx_not_full, rx_overrun, rx_service, irq, dma_req;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  serial_fifo_status i_serial_fifo_status (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
    .rx_thresh(rx_thresh), .rx_irq_en(rx_irq_en), .rx_dma_en(rx_dma_en),
    .ovr_wr(ovr_wr), .ovr_wdata(ovr_wdata),
    .rx_level(rx_level), .tx_level(tx_level), .rx_not_empty(rx_not_empty), .tx_not_full(tx_not_full),
    .rx_overrun(rx_overrun), .rx_service(rx_service), .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rx_put(input logic [DW-1:0] d);
    @(negedge clk);
    rx_push = 1'b1; rx_push_data = d;
    tick();
    rx_push = 1'b0;
  endtask

  task automatic rx_take;
    @(negedge clk);
    rx_pop = 1'b1;
    tick();
    rx_pop = 1'b0;
  endtask

  task automatic tx_put(input logic [DW-1:0] d);
    @(negedge clk);
    tx_push = 1'b1; tx_push_data = d;
    tick();
    tx_push = 1'b0;
  endtask

  task automatic tx_take;
    @(negedge clk);
    tx_pop = 1'b1;
    tick();
    tx_pop = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; port_en = 1'b1;
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    rx_push_data = '0; tx_push_data = '0; rx_thresh = '0;
    rx_irq_en = 0; rx_dma_en = 0; ovr_wr = 0; ovr_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 rx_level", rx_level, 'hF);
    chk("R1 rx_not_empty", rx_not_empty, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 tx_not_full", tx_not_full, 1);
    chk("R1 rx_overrun", rx_overrun, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma_req", dma_req, 0);

    // R2 / R8 / R9 / R10: every count against every trigger level
    for (int k = 0; k <= 16; k++) begin
      chk("R2 rx_level", rx_level, (k + 15) % 16);
      chk("R2 rx_not_empty", rx_not_empty, int'(k != 0));
      for (int t = 0; t < 16; t++) begin
        int es;
        es = int'(k >= t + 1);
        rx_thresh = 4'(t); rx_irq_en = 1; rx_dma_en = 0; #0.5;
        chk("R8 rx_service", rx_service, es);
        chk("R9 irq from service", irq, es);
        chk("R10 dma off", dma_req, 0);
        rx_irq_en = 0; rx_dma_en = 1; #0.5;
        chk("R10 dma from service", dma_req, es);
        chk("R9 irq masked", irq, 0);
        rx_irq_en = 1; #0.5;
        chk("R10 both enables", dma_req, 0);
      end
      rx_irq_en = 0; rx_dma_en = 0;
      if (k < 16) rx_put(16'hA000 + 16'(k));
      else @(negedge clk);
    end

    // R5 push on full drops the word
    rx_put(16'hDEAD);
    chk("R5 rx_level full", rx_level, 'hF);
    chk("R5 rx_not_empty", rx_not_empty, 1);
    chk("R5 rx_overrun", rx_overrun, 1);
    chk("R9 irq unmasked", irq, 1);
    rx_put(16'hBEEF);
    chk("R5 still full", rx_level, 'hF);
    chk("R5 still overrun", rx_overrun, 1);

    chk("R4 oldest word", rx_pop_data, 'hA000);
    rx_take();
    chk("R2 level 15", rx_level, 'hE);
    rx_thresh = 4'hF; rx_dma_en = 1; #0.5;
    chk("R10 overrun no dma", dma_req, 0);
    chk("R9 overrun irq", irq, 1);
    rx_dma_en = 0;

    // R7 write zero, then write one
    @(negedge clk);
    ovr_wr = 1; ovr_wdata = 0;
    tick();
    chk("R7 write zero ignored", rx_overrun, 1);
    ovr_wdata = 1;
    tick();
    ovr_wr = 0; ovr_wdata = 0;
    chk("R7 cleared", rx_overrun, 0);
    chk("R7 irq cleared", irq, 0);

    // R6 push and pop together on full
    rx_put(16'hA010);
    chk("R6 full before", rx_level, 'hF);
    chk("R4 head", rx_pop_data, 'hA001);
    @(negedge clk);
    rx_push = 1; rx_push_data = 16'hB000; rx_pop = 1;
    tick();
    rx_push = 0; rx_pop = 0;
    chk("R6 level", rx_level, 'hF);
    chk("R6 not_empty", rx_not_empty, 1);
    chk("R6 no overrun", rx_overrun, 0);

    // R4 drain in order
    for (int i = 0; i < 16; i++) begin
      int ew;
      ew = (i < 14) ? ('hA002 + i) : ((i == 14) ? 'hA010 : 'hB000);
      chk("R4 order", rx_pop_data, ew);
      rx_take();
    end
    chk("R2 empty level", rx_level, 'hF);
    chk("R2 empty flag", rx_not_empty, 0);
    rx_take();
    chk("R4 pop empty level", rx_level, 'hF);
    chk("R4 pop empty flag", rx_not_empty, 0);
    rx_put(16'hC000);
    chk("R4 after empty pop", rx_level, 0);
    chk("R4 data after empty pop", rx_pop_data, 'hC000);

    // R7 set wins over clear in the same cycle
    for (int i = 1; i < 16; i++) rx_put(16'hC000 + 16'(i));
    @(negedge clk);
    rx_push = 1; rx_push_data = 16'hEEEE; ovr_wr = 1; ovr_wdata = 1;
    tick();
    rx_push = 0; ovr_wr = 0; ovr_wdata = 0;
    chk("R7 set beats clear", rx_overrun, 1);
    chk("R5 level after collision", rx_level, 'hF);

    // R11 / R8 disable
    rx_thresh = 4'h0;
    @(negedge clk);
    port_en = 0; rx_push = 1; rx_push_data = 16'h1111; #0.5;
    chk("R8 service off while disabled", rx_service, 0);
    tick();
    rx_push = 0;
    chk("R11 rx flushed", rx_not_empty, 0);
    chk("R11 rx level", rx_level, 'hF);
    chk("R11 overrun kept", rx_overrun, 1);
    port_en = 1;
    tick();
    chk("R11 push while off ignored", rx_not_empty, 0);
    @(negedge clk);
    ovr_wr = 1; ovr_wdata = 1;
    tick();
    ovr_wr = 0; ovr_wdata = 0;
    chk("R7 final clear", rx_overrun, 0);

    // R3 transmit sweep
    for (int k = 0; k <= 16; k++) begin
      chk("R3 tx_level", tx_level, k % 16);
      chk("R3 tx_not_full", tx_not_full, int'(k < 16));
      if (k < 16) tx_put(16'h5000 + 16'(k));
    end
    tx_put(16'h6666);
    chk("R3 push on full level", tx_level, 0);
    chk("R3 push on full flag", tx_not_full, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R4 tx order", tx_pop_data, 'h5000 + i);
      tx_take();
    end
    chk("R3 tx empty level", tx_level, 0);
    chk("R3 tx empty flag", tx_not_full, 1);
    tx_put(16'h7000); tx_put(16'h7001); tx_put(16'h7002);
    chk("R3 tx three", tx_level, 3);
    @(negedge clk);
    port_en = 0;
    tick();
    port_en = 1;
    chk("R11 tx flushed", tx_level, 0);
    chk("R11 tx not full", tx_not_full, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule